// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This unit compares two single-precision operands and turns their relation (unordered, less, equal or greater) into a six-bit status flag word of the kind a processor condition register holds. One mode bit picks between two flag encodings. The legacy encoding uses only the zero, parity and carry flags. The extended encoding also drives overflow and sign, so that the signed and equality condition codes line up with the usual floating-point relational operators, NaNs included.

An operand pair is offered with `in_valid`. The unit never applies back-pressure: `in_ready` is always high, and every cycle with `in_valid` high transfers a pair. The flags register one clock edge later and hold until the next accepted pair. A condition evaluator reads a 4-bit selector and reports combinationally whether the stored flags satisfy that condition. The selector may change at any time without a new compare.

Top module: `fcmp_flag_unit`

## Requirements
- R1: While `rst_n` is low, `flags` is 6'b000000 and stays so until the first accepted compare.
- R2: `in_ready` is always 1. A pair is accepted on a rising clock edge with `in_valid` high, and `flags` shows its result from that edge on.
- R3: On a rising edge with `in_valid` low, `flags` keeps its value, whatever the operands or `ext_mode` do.
- R4: The relation is unordered when either operand has an all-ones exponent and a nonzero mantissa (quiet or signalling NaN).
- R5: Ordered operands compare by numeric value: +0 equals -0, infinities are the extremes, and subnormals are ordinary nonzero values.
- R6: Flag bit order is {AF,OF,SF,ZF,PF,CF} in bits 5..0. With `ext_mode`=0: unordered 000111, less 000001, equal 000100, greater 000000.
- R7: With `ext_mode`=1: unordered 011011, less 010001, equal 011100, greater 000000.
- R8: AF (bit 5) is 0 after every compare in both modes.
- R9: `cc_sel` values 0..15 select O(OF), NO, B(CF), AE(!CF), E(ZF), NE, BE(CF|ZF), A(!CF&!ZF), S(SF), NS, P(PF), NP, L(SF!=OF), GE(SF==OF), LE(ZF|SF!=OF), G(!ZF&SF==OF). `cc_true` gives the condition applied to the stored flags, combinationally.
- R10: In extended mode E is true only for equal, NE for unordered, less and greater, L only for less, LE for less and equal, A only for greater and AE for greater and equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Always 1; pair taken whenever offered |
| op_a | input | 32 | First single-precision operand |
| op_b | input | 32 | Second single-precision operand |
| ext_mode | input | 1 | 0 legacy flag encoding, 1 extended |
| cc_sel | input | 4 | Condition selector, encoding in R9 |
| flags | output | 6 | Stored flags {AF,OF,SF,ZF,PF,CF} |
| cc_true | output | 1 | Selected condition holds on the stored flags |

## Verification
A wrong relation or encoding shows on `flags` in the cycle after the accepting edge, and the bench reads it there for each table entry. An error in the condition evaluator appears at once on `cc_true`, so all sixteen selectors are swept against each stored result before the next compare. A register that loses its value shows as changed flags after idle cycles or mode changes with `in_valid` low.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  // Relation between the two operands
  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_LT = 2'd1,
    REL_EQ = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  // Flag vector layout, bits 5..0
  localparam int FLAG_W = 6;
  localparam int F_CF = 0;
  localparam int F_PF = 1;
  localparam int F_ZF = 2;
  localparam int F_SF = 3;
  localparam int F_OF = 4;
  localparam int F_AF = 5;

  // Condition pairs: selector bits [3:1] pick the base test,
  // selector bit 0 inverts it.
  localparam int CC_W = 4;
  typedef enum logic [2:0] {
    CCB_O  = 3'd0,
    CCB_B  = 3'd1,
    CCB_E  = 3'd2,
    CCB_BE = 3'd3,
    CCB_S  = 3'd4,
    CCB_P  = 3'd5,
    CCB_L  = 3'd6,
    CCB_LE = 3'd7
  } cc_base_e;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] op_a,
  input  logic [EXP_W+MAN_W:0] op_b,
  output rel_e                 rel
);
  localparam int W     = EXP_W + MAN_W + 1;
  localparam int MAG_W = W - 1;

  logic [W-1:0]     ops     [2];
  logic [1:0]       is_nan;
  logic [1:0]       is_zero;
  logic [1:0]       sgn;
  logic [MAG_W-1:0] mag     [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar k = 0; k < 2; k++) begin : g_op
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;
    assign sgn[k]     = ops[k][W-1];
    assign mag[k]     = ops[k][MAG_W-1:0];
    assign ex         = ops[k][MAG_W-1:MAN_W];
    assign mn         = ops[k][MAN_W-1:0];
    assign is_nan[k]  = (&ex) && (|mn);
    assign is_zero[k] = (mag[k] == '0);
  end

  logic mag_lt, mag_eq;
  assign mag_lt = (mag[0] < mag[1]);
  assign mag_eq = (mag[0] == mag[1]);

  always_comb begin
    if (|is_nan) begin
      rel = REL_UN;
    end else if (&is_zero) begin
      rel = REL_EQ;
    end else if (sgn[0] != sgn[1]) begin
      rel = sgn[0] ? REL_LT : REL_GT;
    end else if (mag_eq) begin
      rel = REL_EQ;
    end else if (mag_lt ^ sgn[0]) begin
      rel = REL_LT;
    end else begin
      rel = REL_GT;
    end
  end
endmodule

// File: rtl/fcmp_flag_encode.sv
module fcmp_flag_encode
  import fcmp_pkg::*;
(
  input  rel_e              rel,
  input  logic              ext_mode,
  output logic [FLAG_W-1:0] flag_nx
);
  always_comb begin
    flag_nx = '0;
    unique case (rel)
      REL_UN: begin
        flag_nx[F_PF] = 1'b1;
        flag_nx[F_CF] = 1'b1;
        flag_nx[F_ZF] = ~ext_mode;
        flag_nx[F_OF] = ext_mode;
        flag_nx[F_SF] = ext_mode;
      end
      REL_LT: begin
        flag_nx[F_CF] = 1'b1;
        flag_nx[F_OF] = ext_mode;
      end
      REL_EQ: begin
        flag_nx[F_ZF] = 1'b1;
        flag_nx[F_OF] = ext_mode;
        flag_nx[F_SF] = ext_mode;
      end
      default: flag_nx = '0;
    endcase
    flag_nx[F_AF] = 1'b0;
  end
endmodule

// File: rtl/fcmp_cc_eval.sv
module fcmp_cc_eval
  import fcmp_pkg::*;
(
  input  logic [FLAG_W-1:0] flg,
  input  logic [CC_W-1:0]   sel,
  output logic              hit
);
  cc_base_e base;
  logic     raw;
  logic     s_ne_o;

  assign base   = cc_base_e'(sel[CC_W-1:1]);
  assign s_ne_o = flg[F_SF] ^ flg[F_OF];

  always_comb begin
    unique case (base)
      CCB_O:   raw = flg[F_OF];
      CCB_B:   raw = flg[F_CF];
      CCB_E:   raw = flg[F_ZF];
      CCB_BE:  raw = flg[F_CF] | flg[F_ZF];
      CCB_S:   raw = flg[F_SF];
      CCB_P:   raw = flg[F_PF];
      CCB_L:   raw = s_ne_o;
      default: raw = flg[F_ZF] | s_ne_o;
    endcase
  end

  assign hit = raw ^ sel[0];
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [EXP_W+MAN_W:0] op_a,
  input  logic [EXP_W+MAN_W:0] op_b,
  input  logic                 ext_mode,
  input  logic [3:0]           cc_sel,
  output logic [5:0]           flags,
  output logic                 cc_true
);
  rel_e              rel;
  logic [FLAG_W-1:0] flag_nx;
  logic [FLAG_W-1:0] flag_q;

  assign in_ready = 1'b1;

  fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_classify (
    .op_a (op_a),
    .op_b (op_b),
    .rel  (rel)
  );

  fcmp_flag_encode u_encode (
    .rel      (rel),
    .ext_mode (ext_mode),
    .flag_nx  (flag_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (in_valid) begin
      flag_q <= flag_nx;
    end
  end

  fcmp_cc_eval u_cc (
    .flg (flag_q),
    .sel (cc_sel),
    .hit (cc_true)
  );

  assign flags = flag_q;
endmodule

// File: rtl/fcmp_flag_unit_sva.sv
module fcmp_flag_unit_sva #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [EXP_W+MAN_W:0] op_a,
  input logic [EXP_W+MAN_W:0] op_b,
  input logic                 ext_mode,
  input logic [3:0]           cc_sel,
  input logic [5:0]           flags,
  input logic                 cc_true
);
  localparam int W = EXP_W + MAN_W + 1;

  logic a_nan, b_nan;
  assign a_nan = (op_a[W-2:MAN_W] == '1) && (op_a[MAN_W-1:0] != '0);
  assign b_nan = (op_b[W-2:MAN_W] == '1) && (op_b[MAN_W-1:0] != '0);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (flags == 6'b0));

  assert_ready_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(flags));

  assert_nan_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (a_nan || b_nan)) |=> flags[1]);

  assert_legacy_no_of_sf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ext_mode) |=> (flags[4:3] == 2'b00));

  assert_ext_unordered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ext_mode && (a_nan || b_nan)) |=> (flags == 6'b011011));

  assert_af_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !flags[5]);

  assert_parity_implies_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flags[1] |-> flags[0]);

  assert_equal_cc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_sel == 4'd4) |-> (cc_true == flags[2]));

  assert_below_cc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_sel == 4'd2) |-> (cc_true == flags[0]));
endmodule

bind fcmp_flag_unit fcmp_flag_unit_sva #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sva (.*);

// File: tb/test_fcmp_flag_unit.sv
`timescale 1ns/1ps
module test_fcmp_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        ext_mode = 1'b0;
  logic [3:0]  cc_sel = '0;
  logic [5:0]  flags;
  logic        cc_true;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fcmp_flag_unit i_fcmp_flag_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .ext_mode(ext_mode), .cc_sel(cc_sel),
    .flags(flags), .cc_true(cc_true)
  );

  localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000;
  localparam logic [31:0] N1 = 32'hBF80_0000, N2 = 32'hC000_0000;
  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] QN = 32'h7FC0_0000, SN = 32'h7F80_0001;
  localparam logic [31:0] PI = 32'h7F80_0000, NI = 32'hFF80_0000;
  localparam logic [31:0] DN = 32'h0000_0001;

  localparam logic [5:0] LU = 6'b000111, LL = 6'b000001, LE_ = 6'b000100;
  localparam logic [5:0] XU = 6'b011011, XL = 6'b010001, XE = 6'b011100;
  localparam logic [5:0] GT = 6'b000000;

  // {op_a, op_b, ext_mode, expected flags}
  localparam int NV = 18;
  localparam logic [70:0] VEC [NV] = '{
    {P1, P2, 1'b0, LL}, {P2, P1, 1'b0, GT}, {P1, P1, 1'b0, LE_},
    {N1, N2, 1'b1, GT}, {N2, N1, 1'b1, XL}, {PZ, NZ, 1'b1, XE},
    {NZ, PZ, 1'b0, LE_}, {QN, P1, 1'b0, LU}, {P1, SN, 1'b1, XU},
    {PI, QN, 1'b0, LU}, {PI, P1, 1'b1, GT}, {NI, N1, 1'b1, XL},
    {DN, PZ, 1'b1, GT}, {N1, P1, 1'b0, LL}, {PI, PI, 1'b1, XE},
    {NI, PI, 1'b1, XL}, {P1, P2, 1'b1, XL}, {SN, QN, 1'b1, XU}
  };

  function automatic logic exp_cc(input logic [5:0] f, input logic [3:0] s);
    logic o, sg, z, p, c;
    {o, sg, z, p, c} = f[4:0];
    case (s)
      4'd0:  return o;
      4'd1:  return !o;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return z;
      4'd5:  return !z;
      4'd6:  return c || z;
      4'd7:  return !c && !z;
      4'd8:  return sg;
      4'd9:  return !sg;
      4'd10: return p;
      4'd11: return !p;
      4'd12: return sg != o;
      4'd13: return sg == o;
      4'd14: return z || (sg != o);
      default: return !z && (sg == o);
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Offer one pair; return at the negedge after the accepting edge.
  task automatic compare(input logic [31:0] a, input logic [31:0] b, input logic m);
    @(negedge clk);
    op_a = a; op_b = b; ext_mode = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic sweep_cc(input logic [5:0] f);
    for (int s = 0; s < 16; s++) begin
      cc_sel = 4'(s);
      #0.2;
      check($sformatf("R9 sel=%0d", s), {31'd0, cc_true}, {31'd0, exp_cc(f, 4'(s))});
    end
  endtask

  task automatic expect_cc(input string tag, input logic [3:0] s, input logic e);
    cc_sel = s;
    #0.2;
    check(tag, {31'd0, cc_true}, {31'd0, e});
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 flags in reset", {26'd0, flags}, 32'd0);
    check("R2 ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flags after reset", {26'd0, flags}, 32'd0);
    expect_cc("R1 A true on cleared flags", 4'd7, 1'b1);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [5:0] ef;
      string tg;
      ef = VEC[i][5:0];
      compare(VEC[i][70:39], VEC[i][38:7], VEC[i][6]);
      if (ef == LU || ef == XU) tg = "R4";
      else if (VEC[i][6]) tg = "R7";
      else tg = "R6";
      check($sformatf("%s vec%0d flags", tg, i), {26'd0, flags}, {26'd0, ef});
      check($sformatf("R8 vec%0d AF", i), {31'd0, flags[5]}, 32'd0);
      check($sformatf("R2 vec%0d ready", i), {31'd0, in_ready}, 32'd1);
      sweep_cc(ef);
    end

    // R5: signed zeros and subnormal ordering
    compare(NZ, PZ, 1'b1);
    check("R5 -0 vs +0 equal", {26'd0, flags}, {26'd0, XE});
    compare(DN, NZ, 1'b0);
    check("R5 subnormal vs -0 greater", {26'd0, flags}, {26'd0, GT});
    compare(N1, NI, 1'b1);
    check("R5 -1 vs -inf greater", {26'd0, flags}, {26'd0, GT});

    // R3: idle cycles, operand and mode changes without valid
    compare(P1, P2, 1'b1);
    @(negedge clk);
    op_a = QN; op_b = QN; ext_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 hold on idle", {26'd0, flags}, {26'd0, XL});

    // R2: back-to-back valid, each edge updates
    @(negedge clk);
    op_a = P2; op_b = P1; ext_mode = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R2 first of burst", {26'd0, flags}, {26'd0, GT});
    op_a = P1; op_b = P1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 second of burst", {26'd0, flags}, {26'd0, XE});

    // R10: extended-mode operator mapping
    compare(QN, P1, 1'b1);
    expect_cc("R10 E false on unordered", 4'd4, 1'b0);
    expect_cc("R10 NE true on unordered", 4'd5, 1'b1);
    expect_cc("R10 L false on unordered", 4'd12, 1'b0);
    expect_cc("R10 AE false on unordered", 4'd3, 1'b0);
    compare(N2, P1, 1'b1);
    expect_cc("R10 L true on less", 4'd12, 1'b1);
    expect_cc("R10 LE true on less", 4'd14, 1'b1);
    expect_cc("R10 NE true on less", 4'd5, 1'b1);
    compare(P1, P1, 1'b1);
    expect_cc("R10 LE true on equal", 4'd14, 1'b1);
    expect_cc("R10 L false on equal", 4'd12, 1'b0);
    expect_cc("R10 AE true on equal", 4'd3, 1'b1);
    compare(P2, N1, 1'b1);
    expect_cc("R10 A true on greater", 4'd7, 1'b1);
    expect_cc("R10 E false on greater", 4'd4, 1'b0);
    // legacy contrast: E set for unordered
    compare(SN, P1, 1'b0);
    expect_cc("R6 legacy E on unordered", 4'd4, 1'b1);

    // R1: reset in mid-run clears stored flags
    compare(QN, QN, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset clears", {26'd0, flags}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 stays clear after reset", {26'd0, flags}, 32'd0);

    finish_run();
  end
endmodule